// File: doc/BRIEF.md
# Integer Execution Unit for a Register Virtual Machine

This block is the arithmetic core of a small register-based virtual machine. Each operation is computed in a single cycle from its inputs with no internal state. The caller supplies an operation code, the current destination register value and a second operand. That operand is a source register, a word loaded from memory, or a sign-handled immediate, and the caller selects among these before the block. The caller also supplies the raw 32-bit immediate, a flag saying whether the source and destination fields name the same register, and a 64-bit reciprocal computed elsewhere from the immediate.

The block returns a new destination value and a new source value, each with its own write strobe. The source value is written back only by the exchange operation.

The operations are:

- the upper half of a full-width unsigned product,
- the upper half of a full-width signed product,
- multiplication by a precomputed reciprocal,
- two's-complement negation,
- exclusive OR,
- register exchange,
- a floating-point negate-and-rescale, done as one fixed bit mask on a 64-bit lane.

An operation that must leave the registers alone drops both write strobes. In that case the block echoes its operands back unchanged.

Top module: `vmx_int_exu`

## Requirements
- R1: Code 0 (unsigned high multiply) drives `dst_new` with bits [127:64] of the 128-bit unsigned product of `dst_val` and `src_val`, with `dst_we`=1 and `src_we`=0.
- R2: Code 1 (signed high multiply) drives `dst_new` with bits [127:64] of the 128-bit two's-complement product of `dst_val` and `src_val`, with `dst_we`=1. Its result differs from code 0 whenever exactly the sign handling matters.
- R3: For codes 0 and 1 the value of `imm_val` has no effect on any output. When `same_reg`=1 and the two operands are equal, the result is the high half of the square.
- R4: Code 2 (reciprocal multiply) with a non-zero `imm_val` drives `dst_new` with the low 64 bits of `dst_val` times `rcp_val`, with `dst_we`=1. The caller provides `rcp_val` = floor(2^x / imm_val) for the largest integer x that keeps it below 2^64.
- R5: Code 2 with `imm_val`=0 is a no-op: `dst_we`=0, `src_we`=0, and `dst_new` equals `dst_val`.
- R6: Code 3 (negate) drives `dst_new` with the two's-complement negative of `dst_val`, i.e. the bitwise inverse plus one, with `dst_we`=1.
- R7: Code 4 (exclusive OR) drives `dst_new` with `dst_val` XOR `src_val`, with `dst_we`=1.
- R8: Code 5 (exchange) with `same_reg`=0 drives `dst_new` with `src_val` and `src_new` with `dst_val`, with both `dst_we` and `src_we` at 1.
- R9: Code 5 with `same_reg`=1 is a no-op: both write strobes are 0 and the outputs echo the inputs.
- R10: Code 6 (floating-point scale) drives `dst_new` with `dst_val` XOR 0x81F0000000000000, with `dst_we`=1. This negates the double and scales it by an odd power of two between -31 and +31.
- R11: Codes 7 to 15 are no-ops with both strobes 0. `src_we` is 1 only for code 5. Whenever a strobe is 0, the matching output equals its input operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 4 | Operation select (0..6 defined, others no-op) |
| dst_val | input | 64 | Current destination register value |
| src_val | input | 64 | Second operand: source register, memory word or immediate |
| imm_val | input | 32 | Raw instruction immediate |
| same_reg | input | 1 | Source and destination name the same register |
| rcp_val | input | 64 | Reciprocal of the immediate, precomputed by the caller |
| dst_new | output | 64 | Value to write to the destination register |
| src_new | output | 64 | Value to write to the source register (exchange only) |
| dst_we | output | 1 | Destination write strobe |
| src_we | output | 1 | Source write strobe |

## Verification
Every result of this unit is purely combinational, so each output is due in the same cycle its operands are applied, with zero register stages on the way. The bench therefore changes operands on a rising clock edge and samples all four outputs at the following falling edge, half a period later. By then the result has settled and no edge ordering can affect it. Expected values come from 128-bit arithmetic in the bench. The signed high half is derived from the unsigned one by sign correction. The reciprocal is found by searching the exponent downward.

// File: rtl/vmx_pkg.sv
package vmx_pkg;
   localparam int unsigned OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_MULHU = 4'd0,
      OP_MULHS = 4'd1,
      OP_RCPMUL = 4'd2,
      OP_NEG = 4'd3,
      OP_XOR = 4'd4,
      OP_SWAP = 4'd5,
      OP_FSCAL = 4'd6
   } vmx_op_e;

   // sign bit plus low five exponent bits of a double
   localparam logic [63:0] FSCAL_MASK_DEF = 64'h81F0_0000_0000_0000;
endpackage

// File: rtl/vmx_mulhi.sv
module vmx_mulhi #(
   parameter int unsigned W = 64,
   parameter bit SIGNED = 1'b0
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] hi_o
);
   localparam int unsigned PW = 2 * W;

   generate
      if (SIGNED) begin : g_signed
         logic signed [PW-1:0] a_x, b_x, prod;
         assign a_x = $signed({{W{a_i[W-1]}}, a_i});
         assign b_x = $signed({{W{b_i[W-1]}}, b_i});
         assign prod = a_x * b_x;
         assign hi_o = W'($unsigned(prod) >> W);
      end else begin : g_unsigned
         logic [PW-1:0] a_x, b_x, prod;
         assign a_x = {{W{1'b0}}, a_i};
         assign b_x = {{W{1'b0}}, b_i};
         assign prod = a_x * b_x;
         assign hi_o = W'(prod >> W);
      end
   endgenerate
endmodule

// File: rtl/vmx_bitops.sv
module vmx_bitops #(
   parameter int unsigned W = 64,
   parameter logic [W-1:0] FMASK = '0
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] neg_o,
   output logic [W-1:0] xor_o,
   output logic [W-1:0] fscal_o
);
   assign neg_o = ~a_i + W'(1);
   assign xor_o = a_i ^ b_i;
   assign fscal_o = a_i ^ FMASK;
endmodule

// File: rtl/vmx_rcpmul.sv
module vmx_rcpmul #(
   parameter int unsigned W = 64,
   parameter int unsigned IW = 32
) (
   input  logic [W-1:0]  a_i,
   input  logic [W-1:0]  rcp_i,
   input  logic [IW-1:0] imm_i,
   output logic [W-1:0]  prod_o,
   output logic          valid_o
);
   assign prod_o = a_i * rcp_i;
   assign valid_o = |imm_i;
endmodule

// File: rtl/vmx_int_exu.sv
module vmx_int_exu #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned IMM_W = 32,
   parameter logic [DATA_W-1:0] FSCAL_MASK = vmx_pkg::FSCAL_MASK_DEF
) (
   input  logic [3:0]        op_code,
   input  logic [DATA_W-1:0] dst_val,
   input  logic [DATA_W-1:0] src_val,
   input  logic [IMM_W-1:0]  imm_val,
   input  logic              same_reg,
   input  logic [DATA_W-1:0] rcp_val,
   output logic [DATA_W-1:0] dst_new,
   output logic [DATA_W-1:0] src_new,
   output logic              dst_we,
   output logic              src_we
);
   import vmx_pkg::*;

   generate
      if (DATA_W < 8 || IMM_W > DATA_W) begin : g_bad_width
         $error("vmx_int_exu: DATA_W must be >= 8 and >= IMM_W");
      end
   endgenerate

   logic [DATA_W-1:0] hu_w, hs_w, rcp_w, neg_w, xor_w, fs_w;
   logic              rcp_ok;
   vmx_op_e           op;

   assign op = vmx_op_e'(op_code);

   vmx_mulhi #(.W(DATA_W), .SIGNED(1'b0)) u_mulhu (
      .a_i(dst_val), .b_i(src_val), .hi_o(hu_w));

   vmx_mulhi #(.W(DATA_W), .SIGNED(1'b1)) u_mulhs (
      .a_i(dst_val), .b_i(src_val), .hi_o(hs_w));

   vmx_rcpmul #(.W(DATA_W), .IW(IMM_W)) u_rcp (
      .a_i(dst_val), .rcp_i(rcp_val), .imm_i(imm_val),
      .prod_o(rcp_w), .valid_o(rcp_ok));

   vmx_bitops #(.W(DATA_W), .FMASK(FSCAL_MASK)) u_bits (
      .a_i(dst_val), .b_i(src_val),
      .neg_o(neg_w), .xor_o(xor_w), .fscal_o(fs_w));

   always_comb begin
      dst_new = dst_val;
      src_new = src_val;
      dst_we  = 1'b0;
      src_we  = 1'b0;
      case (op)
         OP_MULHU: begin dst_new = hu_w; dst_we = 1'b1; end
         OP_MULHS: begin dst_new = hs_w; dst_we = 1'b1; end
         OP_RCPMUL: begin
            if (rcp_ok) begin
               dst_new = rcp_w;
               dst_we  = 1'b1;
            end
         end
         OP_NEG:   begin dst_new = neg_w; dst_we = 1'b1; end
         OP_XOR:   begin dst_new = xor_w; dst_we = 1'b1; end
         OP_SWAP: begin
            if (!same_reg) begin
               dst_new = src_val;
               src_new = dst_val;
               dst_we  = 1'b1;
               src_we  = 1'b1;
            end
         end
         OP_FSCAL: begin dst_new = fs_w; dst_we = 1'b1; end
         default: ;
      endcase
   end
endmodule

// File: rtl/vmx_exu_chk.sv
module vmx_exu_chk #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned IMM_W = 32,
   parameter logic [DATA_W-1:0] FSCAL_MASK = '0
) (
   input logic [3:0]        op_code,
   input logic [DATA_W-1:0] dst_val,
   input logic [DATA_W-1:0] src_val,
   input logic [IMM_W-1:0]  imm_val,
   input logic              same_reg,
   input logic [DATA_W-1:0] dst_new,
   input logic [DATA_W-1:0] src_new,
   input logic              dst_we,
   input logic              src_we
);
   always_comb begin
      if (op_code == 4'd2 && imm_val == '0)
         p_rcp_zero_noop_r5: assert (!dst_we && dst_new == dst_val);
      if (op_code == 4'd3)
         p_neg_sums_zero_r6: assert (dst_new + dst_val == '0);
      if (op_code == 4'd5 && !same_reg)
         p_swap_exchange_r8: assert (dst_new == src_val && src_new == dst_val && dst_we && src_we);
      if (op_code == 4'd5 && same_reg)
         p_swap_alias_noop_r9: assert (!dst_we && !src_we);
      if (op_code == 4'd6)
         p_fscal_mask_r10: assert ((dst_new ^ dst_val) == FSCAL_MASK);
      if (op_code > 4'd6)
         p_unused_noop_r11: assert (!dst_we && !src_we);
      if (src_we)
         p_src_we_swap_only_r11: assert (op_code == 4'd5);
      if (!dst_we)
         p_dst_echo_r11: assert (dst_new == dst_val);
   end
endmodule

bind vmx_int_exu vmx_exu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W), .FSCAL_MASK(FSCAL_MASK)) i_chk (
   .op_code(op_code), .dst_val(dst_val), .src_val(src_val), .imm_val(imm_val),
   .same_reg(same_reg), .dst_new(dst_new), .src_new(src_new),
   .dst_we(dst_we), .src_we(src_we));

// File: tb/test_vmx_int_exu.sv
module test_vmx_int_exu;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic [3:0]  op_code = '0;
   logic [63:0] dst_val = '0, src_val = '0, rcp_val = '0;
   logic [31:0] imm_val = '0;
   logic        same_reg = 1'b0;
   logic [63:0] dst_new, src_new;
   logic        dst_we, src_we;

   int n_vec = 0, n_bad = 0;

   vmx_int_exu i_vmx_int_exu (.*);

   function automatic logic [63:0] ref_hu(logic [63:0] a, logic [63:0] b);
      logic [127:0] p = {64'd0, a} * {64'd0, b};
      return p[127:64];
   endfunction

   function automatic logic [63:0] ref_hs(logic [63:0] a, logic [63:0] b);
      logic [63:0] h = ref_hu(a, b);
      if (a[63]) h = h - b;
      if (b[63]) h = h - a;
      return h;
   endfunction

   function automatic logic [63:0] ref_rcp(logic [31:0] d);
      for (int x = 95; x >= 0; x--) begin
         logic [127:0] q = (128'd1 << x) / {96'd0, d};
         if (q < (128'd1 << 64)) return q[63:0];
      end
      return 64'd0;
   endfunction

   task automatic apply(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b,
                        input logic [31:0] imm, input logic same);
      logic [63:0] ed, es;
      logic        ewd, ews;
      string       tag;
      @(posedge clk);
      op_code = op; dst_val = a; src_val = same ? a : b; imm_val = imm;
      same_reg = same; rcp_val = (imm != 0) ? ref_rcp(imm) : 64'd0;
      ed = a; es = same ? a : b; ewd = 1'b0; ews = 1'b0;
      case (op)
         4'd0: begin tag = (imm[0]) ? "R1/R3" : "R1"; ed = ref_hu(a, es); ewd = 1; end
         4'd1: begin tag = (imm[0]) ? "R2/R3" : "R2"; ed = ref_hs(a, es); ewd = 1; end
         4'd2: if (imm != 0) begin tag = "R4"; ed = a * rcp_val; ewd = 1; end
               else tag = "R5";
         4'd3: begin tag = "R6"; ed = 64'd0 - a; ewd = 1; end
         4'd4: begin tag = "R7"; ed = a ^ es; ewd = 1; end
         4'd5: if (!same) begin tag = "R8"; ed = b; es = a; ewd = 1; ews = 1; end
               else tag = "R9";
         4'd6: begin tag = "R10"; ed = {~a[63], a[62:57], ~a[56:52], a[51:0]}; ewd = 1; end
         default: tag = "R11";
      endcase
      @(negedge clk);
      n_vec++;
      if ({dst_new, src_new, dst_we, src_we} !== {ed, es, ewd, ews}) begin
         n_bad++;
         $display("FAIL %s op=%0d dst=%h src=%h imm=%h : got %h/%h/%b%b exp %h/%h/%b%b",
                  tag, op, a, b, imm, dst_new, src_new, dst_we, src_we, ed, es, ewd, ews);
      end
   endtask

   initial begin
      automatic logic [63:0] corner[6] = '{64'd0, 64'd1, '1, 64'h8000_0000_0000_0000,
                                           64'h7FFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF};
      automatic logic [31:0] imms[5] = '{32'd0, 32'd1, 32'd7, 32'h8000_0000, 32'hFFFF_FFFF};
      // inputs all zero at start: code 0 gives zero product, write strobe set (R1)
      apply(4'd0, 64'd0, 64'd0, 32'd0, 1'b0);
      // near-exhaustive sweep: every code x corner pairs x immediates x alias flag
      // (R1..R11; R3 via varying imm on codes 0/1 and same_reg squaring)
      for (int op = 0; op < 16; op++)
         for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++)
               for (int k = 0; k < 5; k++)
                  apply(op[3:0], corner[i], corner[j], imms[k], (i == j) && k[0]);
      // random operands, all codes
      for (int n = 0; n < 3000; n++) begin
         automatic logic [63:0] a = {$urandom, $urandom};
         automatic logic [63:0] b = {$urandom, $urandom};
         automatic logic [31:0] im = (n % 11 == 0) ? 32'd0 : $urandom;
         apply(4'(n % 16), a, b, im, (n % 13 == 0));
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #1500000;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule